// File: doc/BRIEF.md
# Vector Floating-Point Control and Status Register

This block holds the 32-bit control and status word of a floating-point vector unit. The word carries six sticky exception flags, a denormals-are-zero control, six exception mask bits, a two-bit rounding mode and a flush-to-zero control. Software writes it through a single strobe-and-data port and reads it back combinationally. Exception logic elsewhere reports events through a six-bit set-flags input, and those bits accumulate until software clears them.

Which bits are writable depends on a build parameter that says whether the denormals-are-zero feature is present. The resulting capability mask is an output of its own, so software can read it as a feature-flag word. A write that sets any bit the mask marks as reserved does not change the register. Instead, the block raises a one-cycle protection-fault pulse in the same cycle as the strobe.

Cold reset and the soft initialisation input behave differently. Only cold reset loads the power-up value. Soft initialisation freezes the register for as long as it is held. A state-save port returns the words of a save image by word index: the register sits at bytes 24–27 and the capability mask at bytes 28–31.

Top module: `vcsr_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register loads 0x00001F80. That value has flags [5:0]=0, denormals-are-zero [6]=0, masks [12:7] all 1, rounding [14:13]=00 and flush-to-zero [15]=0.
- R2: `cap_mask` reads 0x0000FFBF when `DAZ_EN`=0 and 0x0000FFFF when `DAZ_EN`=1. A 0 in `cap_mask` marks a reserved bit.
- R3: A write (`wr_en`=1, `init_req`=0) with no bit set outside `cap_mask` loads the register at the next rising edge. `rd_data` shows the current register value combinationally.
- R4: A write with any bit set where `cap_mask` is 0 drives `fault` high in the same cycle as `wr_en` and leaves bits 31:6 unchanged. `flag_set` still ORs into bits 5:0 in that cycle. `fault` is low in every other cycle.
- R5: `rd_data[31:16]` always reads 0. `rd_data[6]` always reads 0 when `DAZ_EN`=0.
- R6: Each bit of `flag_set[5:0]` ORs into the matching bit of `rd_data[5:0]` at the next edge. Those bits stay set until an accepted write, or a cold reset, clears them.
- R7: When an accepted write and `flag_set` arrive in the same cycle, the register becomes `wr_data | flag_set`.
- R8: While `init_req` is high, the register keeps its value. Writes and `flag_set` are ignored and `fault` stays low.
- R9: For `snap_idx`=6 (bytes 24–27), `snap_data` returns the register. For `snap_idx`=7 (bytes 28–31), it returns `cap_mask`. Every other index returns 0.
- R10: Any value ANDed with `cap_mask` is written without a fault.
- R11: When `DAZ_EN`=1, bit 6 is writable and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| init_req | input | 1 | Soft initialisation; freezes the register |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| flag_set | input | 6 | Exception events to OR into the sticky flags |
| rd_data | output | 32 | Current register value |
| cap_mask | output | 32 | Writable-bit mask and feature-flag word |
| fault | output | 1 | Protection-fault pulse for an illegal write |
| snap_idx | input | 7 | Save-image word index |
| snap_data | output | 32 | Save-image word at `snap_idx` |

## Verification
Two instances run side by side, one without denormals-are-zero and one with it. Writing bit 6 therefore faults in one instance and loads in the other. A design with the wrong mask would either load the reserved bit or fault on a legal write.

The bench pairs a set-flags pulse with an accepted write and with a faulting write. A design that gives the write priority loses the flags. A design that drops the flags on a fault loses the exception events.

Soft initialisation is applied together with a write that would fault. A design that treats it like reset, or that keeps decoding writes during it, changes the register or pulses `fault`. The snapshot port is probed at both fixed words and at unused words, which catches a swapped offset.

// File: rtl/vcsr_pkg.sv
`timescale 1ns/1ps
package vcsr_pkg;
    localparam int CSR_W  = 32;
    localparam int FLAG_W = 6;
    localparam int DAZ_BIT = 6;

    localparam logic [CSR_W-1:0] CSR_COLD_VALUE = 32'h0000_1F80;
    localparam logic [CSR_W-1:0] MASK_NO_DAZ    = 32'h0000_FFBF;

    localparam int SNAP_CSR_BYTE  = 24;
    localparam int SNAP_MASK_BYTE = 28;

    typedef struct packed {
        logic [15:0]       rsvd;
        logic              ftz;
        logic [1:0]        rnd;
        logic [5:0]        xmask;
        logic              daz;
        logic [FLAG_W-1:0] xflag;
    } csr_t;

    function automatic logic [CSR_W-1:0] writable_mask(input bit daz_en);
        logic [CSR_W-1:0] m;
        m = MASK_NO_DAZ;
        if (daz_en) m[DAZ_BIT] = 1'b1;
        return m;
    endfunction

    function automatic logic has_reserved(input logic [CSR_W-1:0] val,
                                          input logic [CSR_W-1:0] mask);
        return |(val & ~mask);
    endfunction
endpackage

// File: rtl/vcsr_write_check.sv
`timescale 1ns/1ps
module vcsr_write_check
    import vcsr_pkg::*;
#(
    parameter bit DAZ_EN = 1'b0
) (
    input  logic             wr_en,
    input  logic             init_req,
    input  logic [CSR_W-1:0] wr_data,
    output logic [CSR_W-1:0] cap_mask,
    output logic             wr_ok,
    output logic             fault
);
    localparam logic [CSR_W-1:0] MASK = writable_mask(DAZ_EN);

    logic live_wr;
    logic bad_bits;

    assign cap_mask = MASK;
    assign live_wr  = wr_en & ~init_req;
    assign bad_bits = has_reserved(wr_data, MASK);
    assign wr_ok    = live_wr & ~bad_bits;
    assign fault    = live_wr &  bad_bits;
endmodule

// File: rtl/vcsr_state.sv
`timescale 1ns/1ps
module vcsr_state
    import vcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init_req,
    input  logic              wr_ok,
    input  logic [CSR_W-1:0]  wr_data,
    input  logic [FLAG_W-1:0] flag_set,
    output csr_t              state
);
    csr_t loaded;

    always_comb begin
        loaded       = csr_t'(wr_data);
        loaded.xflag = loaded.xflag | flag_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= csr_t'(CSR_COLD_VALUE);
        end else if (!init_req) begin
            if (wr_ok) state <= loaded;
            else       state.xflag <= state.xflag | flag_set;
        end
    end
endmodule

// File: rtl/vcsr_snapshot.sv
`timescale 1ns/1ps
module vcsr_snapshot
    import vcsr_pkg::*;
#(
    parameter int SNAP_BYTES = 512
) (
    input  logic [$clog2(SNAP_BYTES/4)-1:0] snap_idx,
    input  csr_t                            csr,
    input  logic [CSR_W-1:0]                mask,
    output logic [CSR_W-1:0]                snap_data
);
    localparam int IDX_W = $clog2(SNAP_BYTES/4);
    localparam logic [IDX_W-1:0] CSR_WORD  = IDX_W'(SNAP_CSR_BYTE / 4);
    localparam logic [IDX_W-1:0] MASK_WORD = IDX_W'(SNAP_MASK_BYTE / 4);

    always_comb begin
        snap_data = '0;
        if (snap_idx == CSR_WORD)  snap_data = csr;
        if (snap_idx == MASK_WORD) snap_data = mask;
    end
endmodule

// File: rtl/vcsr_unit.sv
`timescale 1ns/1ps
module vcsr_unit
    import vcsr_pkg::*;
#(
    parameter bit DAZ_EN     = 1'b0,
    parameter int SNAP_BYTES = 512
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            init_req,
    input  logic                            wr_en,
    input  logic [31:0]                     wr_data,
    input  logic [5:0]                      flag_set,
    output logic [31:0]                     rd_data,
    output logic [31:0]                     cap_mask,
    output logic                            fault,
    input  logic [$clog2(SNAP_BYTES/4)-1:0] snap_idx,
    output logic [31:0]                     snap_data
);
    csr_t state;
    logic wr_ok;

    vcsr_write_check #(.DAZ_EN(DAZ_EN)) u_check (
        .wr_en    (wr_en),
        .init_req (init_req),
        .wr_data  (wr_data),
        .cap_mask (cap_mask),
        .wr_ok    (wr_ok),
        .fault    (fault)
    );

    vcsr_state u_state (
        .clk      (clk),
        .rst      (rst),
        .init_req (init_req),
        .wr_ok    (wr_ok),
        .wr_data  (wr_data),
        .flag_set (flag_set),
        .state    (state)
    );

    vcsr_snapshot #(.SNAP_BYTES(SNAP_BYTES)) u_snap (
        .snap_idx  (snap_idx),
        .csr       (state),
        .mask      (cap_mask),
        .snap_data (snap_data)
    );

    assign rd_data = state;
endmodule

// File: rtl/vcsr_unit_chk.sv
`timescale 1ns/1ps
module vcsr_unit_chk #(
    parameter bit DAZ_EN = 1'b0
) (
    input logic        clk,
    input logic        rst,
    input logic        init_req,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [5:0]  flag_set,
    input logic [31:0] rd_data,
    input logic        fault
);
    a_r1_cold_value: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> rd_data == 32'h0000_1F80);

    a_r5_reserved_read_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_data[31:16] == 16'h0) && (DAZ_EN || !rd_data[6]));

    a_r4_fault_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        fault |-> (wr_en && !init_req));

    a_r4_fault_holds: assert property (@(posedge clk) disable iff (rst)
        fault |=> rd_data == ($past(rd_data) | {26'h0, $past(flag_set)}));

    a_r7_write_loads: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !init_req && !fault) |=> rd_data == ($past(wr_data) | {26'h0, $past(flag_set)}));

    a_r6_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !init_req) |=> rd_data == ($past(rd_data) | {26'h0, $past(flag_set)}));

    a_r8_init_freezes: assert property (@(posedge clk) disable iff (rst)
        init_req |=> $stable(rd_data));

    a_r8_init_no_fault: assert property (@(posedge clk) disable iff (rst)
        init_req |-> !fault);
endmodule

bind vcsr_unit vcsr_unit_chk #(.DAZ_EN(DAZ_EN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .init_req (init_req),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .flag_set (flag_set),
    .rd_data  (rd_data),
    .fault    (fault)
);

// File: tb/vcsr_unit_tb.sv
`timescale 1ns/1ps
module vcsr_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_req = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [5:0]  flag_set = '0;
    logic [6:0]  snap_idx = '0;

    logic [31:0] rd0, rd1, mask0, mask1, snap0, snap1;
    logic        fault0, fault1;

    int checks = 0;
    int fails  = 0;

    logic [31:0] exp0, exp1;

    localparam logic [31:0] M0 = 32'h0000_FFBF;
    localparam logic [31:0] M1 = 32'h0000_FFFF;

    always #2.5 clk = ~clk;

    vcsr_unit #(.DAZ_EN(1'b0)) u_dut (
        .clk(clk), .rst(rst), .init_req(init_req), .wr_en(wr_en),
        .wr_data(wr_data), .flag_set(flag_set), .rd_data(rd0),
        .cap_mask(mask0), .fault(fault0), .snap_idx(snap_idx), .snap_data(snap0));

    vcsr_unit #(.DAZ_EN(1'b1)) u_dut_daz (
        .clk(clk), .rst(rst), .init_req(init_req), .wr_en(wr_en),
        .wr_data(wr_data), .flag_set(flag_set), .rd_data(rd1),
        .cap_mask(mask1), .fault(fault1), .snap_idx(snap_idx), .snap_data(snap1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle; check faults before the edge and read-back after it.
    task automatic step(input string req, input logic we, input logic [31:0] d,
                        input logic [5:0] fs, input logic ini);
        logic f0, f1;
        @(negedge clk);
        wr_en = we; wr_data = d; flag_set = fs; init_req = ini;
        #1;
        f0 = we && !ini && ((d & ~M0) != 0);
        f1 = we && !ini && ((d & ~M1) != 0);
        chk({req, " fault nodaz"}, {31'h0, fault0}, {31'h0, f0});
        chk({req, " fault daz"},   {31'h0, fault1}, {31'h0, f1});
        if (!ini) begin
            exp0 = (we && !f0) ? (d | {26'h0, fs}) : (exp0 | {26'h0, fs});
            exp1 = (we && !f1) ? (d | {26'h0, fs}) : (exp1 | {26'h0, fs});
        end
        @(negedge clk);
        wr_en = 1'b0; flag_set = '0; init_req = 1'b0;
        #1;
        chk({req, " rd nodaz"}, rd0, exp0);
        chk({req, " rd daz"},   rd1, exp1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        exp0 = 32'h0000_1F80; exp1 = 32'h0000_1F80;
        chk("R1 cold value nodaz", rd0, 32'h0000_1F80);
        chk("R1 cold value daz",   rd1, 32'h0000_1F80);
        chk("R1 no fault", {30'h0, fault0, fault1}, 32'h0);
        chk("R2 mask nodaz", mask0, M0);
        chk("R2 mask daz",   mask1, M1);
    endtask

    task automatic t_legal_write();
        step("R3 write 7F85", 1'b1, 32'h0000_7F85, 6'h0, 1'b0);
        step("R3 write zero", 1'b1, 32'h0000_0000, 6'h0, 1'b0);
    endtask

    task automatic t_faults();
        step("R4 upper reserved", 1'b1, 32'h0001_0000, 6'h0, 1'b0);
        step("R4 R11 bit6",       1'b1, 32'h0000_0040, 6'h0, 1'b0);
        chk("R5 bit6 reads 0 nodaz", {31'h0, rd0[6]}, 32'h0);
        chk("R11 bit6 set daz",      {31'h0, rd1[6]}, 32'h1);
        step("R4 fault keeps flags",  1'b1, 32'h8000_0000, 6'h10, 1'b0);
    endtask

    task automatic t_flags();
        step("R6 set 05",   1'b0, 32'h0, 6'h05, 1'b0);
        step("R6 set 20",   1'b0, 32'h0, 6'h20, 1'b0);
        step("R6 idle",     1'b0, 32'h0, 6'h00, 1'b0);
        step("R7 write+flag", 1'b1, 32'h0000_1F80, 6'h02, 1'b0);
    endtask

    task automatic t_init();
        step("R8 init blocks write", 1'b1, 32'h0000_0000, 6'h01, 1'b1);
        step("R8 init no fault",     1'b1, 32'hFFFF_FFFF, 6'h3F, 1'b1);
    endtask

    task automatic t_mask_and();
        step("R10 and-mask nodaz", 1'b1, 32'hFFFF_FFFF & M0, 6'h0, 1'b0);
        chk("R10 value nodaz", rd0, 32'h0000_FFBF);
        step("R10 and-mask daz", 1'b1, 32'hFFFF_FFFF & M1, 6'h0, 1'b0);
        chk("R10 value daz", rd1, 32'h0000_FFFF);
    endtask

    task automatic t_snapshot();
        step("R9 preload", 1'b1, 32'h0000_2A05, 6'h0, 1'b0);
        snap_idx = 7'd6; #1;
        chk("R9 word6 nodaz", snap0, 32'h0000_2A05);
        chk("R9 word6 daz",   snap1, 32'h0000_2A05);
        snap_idx = 7'd7; #1;
        chk("R9 word7 nodaz", snap0, M0);
        chk("R9 word7 daz",   snap1, M1);
        snap_idx = 7'd0; #1;
        chk("R9 word0", snap0, 32'h0);
        snap_idx = 7'd127; #1;
        chk("R9 word127", snap1, 32'h0);
        snap_idx = 7'd5; #1;
        chk("R9 word5", snap0, 32'h0);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_legal_write();
        t_faults();
        t_flags();
        t_init();
        t_mask_and();
        t_snapshot();
        t_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule